// File: doc/BRIEF.md
# Decimal Digit Up/Down Counter with Cascade Outputs

This block holds one decimal digit (0 to 9) and steps it up or down by one on each rising clock edge while its active-low enable is asserted. A direction input picks the sense of counting. An asynchronous active-low preset copies a 4-bit data value into the digit the moment it is asserted, whatever the clock is doing. A synchronous active-low reset clears the digit to zero.

Two combinational outputs let digits be chained into a multi-digit counter. The terminal flag is high when the next enabled step will wrap: the digit is 9 while counting up, or 0 while counting down. The active-low ripple output pulses low under the same terminal condition, but only while the clock is low and the enable is asserted. Feeding one digit's ripple output to the next digit's enable, with a shared clock, gives a synchronous decade chain.

Top module: `bcd_digit_counter`

## Requirements
- R1: With the preset inactive, a rising edge that samples the reset low sets the digit to 0.
- R2: A rising edge that samples the enable high leaves the digit unchanged.
- R3: With the enable low, a rising edge raises the digit by one from 0..8 when the direction input is 0 (up), and lowers it by one from 1..9 when the direction input is 1 (down).
- R4: Counting up wraps from 9 to 0; counting down wraps from 0 to 9.
- R5: A loaded value from 10 to 15 goes to 0 on the next enabled up edge and to 9 on the next enabled down edge.
- R6: While the preset is low, the count output equals the data input at once, with no clock edge, and the preset overrides both enable and reset; after release the loaded value stays.
- R7: The terminal flag is 1 exactly when the count is 9 and the direction is up, or the count is 0 and the direction is down; it is 0 for the values 10 to 15.
- R8: The ripple output is 0 exactly when the clock is low, the enable is low and the terminal flag is 1; otherwise it is 1.
- R9: Changes on the enable and direction inputs between rising edges do not change the count.
- R10: Preset to 7, then counting up gives 8, 9, 0, 1, 2; one disabled edge holds 2; counting down then gives 1, 0, 9, 8, 7.
- R11: Two digits sharing a clock, with the low digit's ripple output driving the high digit's enable, count 00 to 99 and wrap to 00 when counting up, and back through 99 to 00 when counting down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising-edge active; its low phase gates the ripple output |
| rst_n | input | 1 | Synchronous active-low clear |
| en_n | input | 1 | Active-low count enable |
| dn | input | 1 | Direction: 0 counts up, 1 counts down |
| load_n | input | 1 | Asynchronous active-low preset |
| data_i | input | 4 | Preset value |
| q_o | output | 4 | Current digit |
| tc_o | output | 1 | Terminal flag for the selected direction |
| ripple_n_o | output | 1 | Active-low cascade pulse during the clock low phase |

## Verification
The count output moves one register stage after a rising edge, so each count is sampled one time unit after the edge that produced it, while preset results appear with no edge and are sampled a time unit after the preset falls. The terminal flag and ripple output have no register at all: they are sampled in the middle of the clock low phase, where a terminal ripple must be low, and again just after the rising edge, where it must be high. The chained pair is checked one time unit after every edge against a two-digit value held in the bench, with a one-unit wire delay on the ripple-to-enable path so that the high digit sees the enable level that held before the edge.

// File: rtl/bcd_cnt_pkg.sv
// Package: shared types and helpers for the decimal digit counter.
// Assumes the radix is at least 2.
package bcd_cnt_pkg;

    // Direction encoding as seen on the dn pin.
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;

    // Bits needed to hold a value of 0..radix-1.
    function automatic int unsigned cnt_width(input int unsigned radix);
        return (radix <= 2) ? 1 : $clog2(radix);
    endfunction

endpackage

// File: rtl/bcd_step.sv
// Module: bcd_step
// Computes the value one step up or down from the current count.
// Any value at or above RADIX-1 steps up to 0; zero or any value at or
// above RADIX steps down to RADIX-1. Purely combinational.
module bcd_step
    import bcd_cnt_pkg::*;
#(
    parameter int unsigned RADIX = 10,
    parameter int unsigned CNT_W = cnt_width(RADIX)
) (
    input  logic [CNT_W-1:0] cur_i,
    input  cnt_dir_e         dir_i,
    output logic [CNT_W-1:0] nxt_o
);

    localparam logic [CNT_W-1:0] TOP = CNT_W'(RADIX - 1);

    // Next value for the selected direction, folding illegal codes back in range.
    always_comb begin
        if (dir_i == DIR_UP) begin
            nxt_o = (cur_i >= TOP) ? '0 : cur_i + 1'b1;
        end else begin
            nxt_o = ((cur_i == '0) || (cur_i > TOP)) ? TOP : cur_i - 1'b1;
        end
    end

endmodule

// File: rtl/bcd_term.sv
// Module: bcd_term
// Flags the terminal value for the selected direction: RADIX-1 when
// counting up, 0 when counting down. Out-of-range values never flag.
module bcd_term
    import bcd_cnt_pkg::*;
#(
    parameter int unsigned RADIX = 10,
    parameter int unsigned CNT_W = cnt_width(RADIX)
) (
    input  logic [CNT_W-1:0] val_i,
    input  cnt_dir_e         dir_i,
    output logic             tc_o
);

    localparam logic [CNT_W-1:0] TOP = CNT_W'(RADIX - 1);

    // Terminal decode per direction.
    always_comb begin
        unique case (dir_i)
            DIR_UP:   tc_o = (val_i == TOP);
            DIR_DOWN: tc_o = (val_i == '0);
            default:  tc_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bcd_store.sv
// Module: bcd_store
// Holds the count. The preset is asynchronous (captured when load_n falls
// and at every rising edge while it stays low); otherwise a rising edge
// applies the synchronous clear, or the advance value when adv_i is set.
// Assumes data_i is stable while load_n is low.
module bcd_store #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic [CNT_W-1:0] data_i,
    input  logic             adv_i,
    input  logic [CNT_W-1:0] nxt_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;

    // Count register: preset first, then clear, then advance.
    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n) begin
            cnt_q <= data_i;
        end else if (!rst_n) begin
            cnt_q <= '0;
        end else if (adv_i) begin
            cnt_q <= nxt_i;
        end
    end

    assign cnt_o = cnt_q;

    // R2: no advance request means the stored value holds over the edge.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n || !load_n)
        (load_n && !adv_i) |=> $stable(cnt_q));

endmodule

// File: rtl/bcd_digit_counter.sv
// Module: bcd_digit_counter
// One decimal digit that counts up or down, with an asynchronous preset,
// a synchronous clear and two combinational cascade outputs. The terminal
// flag and ripple pulse are derived from the visible count, so during a
// preset they follow the preset value.
module bcd_digit_counter
    import bcd_cnt_pkg::*;
#(
    parameter int unsigned RADIX = 10,
    parameter int unsigned CNT_W = cnt_width(RADIX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_n,
    input  logic             dn,
    input  logic             load_n,
    input  logic [CNT_W-1:0] data_i,
    output logic [CNT_W-1:0] q_o,
    output logic             tc_o,
    output logic             ripple_n_o
);

    localparam logic [CNT_W-1:0] TOP = CNT_W'(RADIX - 1);

    cnt_dir_e         dir;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             term;

    // Map the direction pin onto the shared encoding.
    assign dir = cnt_dir_e'(dn);

    bcd_step #(.RADIX(RADIX), .CNT_W(CNT_W)) u_step (
        .cur_i (cnt_q),
        .dir_i (dir),
        .nxt_o (cnt_nxt)
    );

    bcd_store #(.CNT_W(CNT_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_n (load_n),
        .data_i (data_i),
        .adv_i  (!en_n),
        .nxt_i  (cnt_nxt),
        .cnt_o  (cnt_q)
    );

    // Visible count: the preset value shows through at once while load_n is low.
    assign q_o = load_n ? cnt_q : data_i;

    bcd_term #(.RADIX(RADIX), .CNT_W(CNT_W)) u_term (
        .val_i (q_o),
        .dir_i (dir),
        .tc_o  (term)
    );

    // Cascade outputs: flag as decoded, pulse gated by the clock low phase.
    assign tc_o       = term;
    assign ripple_n_o = ~(~clk & ~en_n & term);

    // R3: an enabled up edge below the top value adds one.
    p_up_step_r3: assert property (@(posedge clk) disable iff (!rst_n || !load_n)
        (load_n && !en_n && !dn && cnt_q < TOP) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    // R3: an enabled down edge inside 1..top subtracts one.
    p_dn_step_r3: assert property (@(posedge clk) disable iff (!rst_n || !load_n)
        (load_n && !en_n && dn && cnt_q != '0 && cnt_q <= TOP) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

    // R4 and R5: up from the top value or any illegal value lands on zero.
    p_up_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n || !load_n)
        (load_n && !en_n && !dn && cnt_q >= TOP) |=> (cnt_q == '0));

    // R4 and R5: down from zero or any illegal value lands on the top value.
    p_dn_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n || !load_n)
        (load_n && !en_n && dn && (cnt_q == '0 || cnt_q > TOP)) |=> (cnt_q == TOP));

    // R4: a legal count never leaves the legal range by counting.
    p_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n || !load_n)
        (load_n && cnt_q <= TOP) |=> (cnt_q <= TOP));

    // R8: in the low phase before an edge, a terminal enabled digit pulls ripple low.
    p_ripple_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && tc_o) |-> !ripple_n_o);

    // R8: during the high phase ripple stays high.
    p_ripple_high_r8: assert property (@(negedge clk) disable iff (!rst_n)
        1'b1 |-> ripple_n_o);

    // R7: ripple low always comes with a raised terminal flag.
    p_ripple_needs_tc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ripple_n_o |-> tc_o);

endmodule

// File: tb/bcd_digit_counter_bench.sv
// Bench: one stand-alone digit swept over all codes and directions, the
// reference load/count/hold sequence, and a two-digit chain checked
// against an arithmetic model.
module bcd_digit_counter_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_n = 1'b1;
    logic       dn = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] data = 4'd0;
    logic [3:0] q;
    logic       tc;
    logic       rip_n;

    logic       c_en_n = 1'b1;
    logic       c_dn = 1'b0;
    logic [3:0] q_lo;
    logic [3:0] q_hi;
    logic       tc_lo;
    logic       tc_hi;
    logic       rip_lo_n;
    logic       rip_hi_n;
    logic       en_hi_n;

    int n_chk = 0;
    int n_bad = 0;
    int exp_q = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bcd_digit_counter u_bcd_digit_counter (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .dn(dn), .load_n(load_n),
        .data_i(data), .q_o(q), .tc_o(tc), .ripple_n_o(rip_n)
    );

    // Wire delay on the cascade path so the high digit sees pre-edge enable.
    assign #1 en_hi_n = rip_lo_n;

    bcd_digit_counter u_lo (
        .clk(clk), .rst_n(rst_n), .en_n(c_en_n), .dn(c_dn), .load_n(1'b1),
        .data_i(4'd0), .q_o(q_lo), .tc_o(tc_lo), .ripple_n_o(rip_lo_n)
    );

    bcd_digit_counter u_hi (
        .clk(clk), .rst_n(rst_n), .en_n(en_hi_n), .dn(c_dn), .load_n(1'b1),
        .data_i(4'd0), .q_o(q_hi), .tc_o(tc_hi), .ripple_n_o(rip_hi_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int tc_model(input int v, input logic down);
        return ((!down && v == 9) || (down && v == 0)) ? 1 : 0;
    endfunction

    function automatic int next_model(input int v, input logic down);
        if (!down) return (v >= 9) ? 0 : v + 1;
        return (v == 0 || v > 9) ? 9 : v - 1;
    endfunction

    // One clock: check flag and ripple in the low phase, count after the edge.
    task automatic step(input string req);
        @(negedge clk); #1;
        check({req, " R7 tc"}, int'(tc), tc_model(exp_q, dn));
        check({req, " R8 ripple low phase"}, int'(rip_n),
              (tc_model(exp_q, dn) == 1 && !en_n) ? 0 : 1);
        @(posedge clk); #1;
        if (!en_n) exp_q = next_model(exp_q, dn);
        check({req, " count"}, int'(q), exp_q);
        check({req, " R8 ripple high phase"}, int'(rip_n), 1);
    endtask

    // Preset spanning one rising edge; entered just after an edge.
    task automatic preset(input int v);
        data = 4'(v);
        load_n = 1'b0;
        #1;
        check("R6 immediate preset", int'(q), v);
        @(posedge clk); #1;
        check("R6 preset over edge", int'(q), v);
        load_n = 1'b1;
        #1;
        check("R6 value kept after release", int'(q), v);
        exp_q = v;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int cval;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset value", int'(q), 0);
        check("R11 chain reset low", int'(q_lo), 0);
        check("R11 chain reset high", int'(q_hi), 0);
        rst_n = 1'b1;

        // R1: clear after a preset.
        preset(5);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1 clear after preset", int'(q), 0);
        // R6: preset overrides an active clear.
        data = 4'd3;
        load_n = 1'b0;
        @(posedge clk); #1;
        check("R6 preset beats clear", int'(q), 3);
        load_n = 1'b1;
        rst_n = 1'b1;
        exp_q = 3;

        // R10: reference sequence.
        preset(7);
        en_n = 1'b0; dn = 1'b0;
        for (int i = 0; i < 5; i++) step("R10 up");
        check("R10 up end", int'(q), 2);
        en_n = 1'b1;
        step("R10 R2 hold");
        check("R10 held", int'(q), 2);
        en_n = 1'b0; dn = 1'b1;
        for (int i = 0; i < 5; i++) step("R10 down");
        check("R10 down end", int'(q), 7);

        // R9: toggle controls between edges; the count must not move.
        en_n = 1'b1;
        #2; en_n = 1'b0; dn = 1'b0;
        #1; dn = 1'b1;
        #1; check("R9 mid-cycle controls", int'(q), 7);
        en_n = 1'b1;
        step("R9 R2 hold after toggles");

        // R3 R4 R5 R7 R8: every code, both directions, enabled and disabled.
        for (int v = 0; v < 16; v++) begin
            for (int d = 0; d < 2; d++) begin
                en_n = 1'b1;
                dn = d[0];
                preset(v);
                step("R2 disabled edge");
                en_n = 1'b0;
                step(v > 9 ? "R5 illegal code" : (tc_model(v, d[0]) == 1 ? "R4 wrap" : "R3 step"));
            end
        end
        en_n = 1'b1;

        // R11: two-digit chain up through 99 and wrap, then back down.
        cval = 0;
        c_dn = 1'b0;
        c_en_n = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); #1;
            cval = (cval + 1) % 100;
            check("R11 chain up", int'(q_hi) * 10 + int'(q_lo), cval);
        end
        c_dn = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); #1;
            cval = (cval + 99) % 100;
            check("R11 chain down", int'(q_hi) * 10 + int'(q_lo), cval);
        end
        c_en_n = 1'b1;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule